// File: doc/BRIEF.md
# Compressed Instruction Expander with Reassigned Floating-Point Slots

This combinational unit sits in the fetch path of a 32-bit integer core. It receives one 32-bit fetch word and returns the 32-bit base instruction that the execute stages consume. When the two low bits are `11`, the word is already a full-length instruction and passes through unchanged. Otherwise the low halfword is a compressed instruction and is rebuilt into its base-ISA equivalent. An illegal flag is raised for encodings that have no meaning.

The compressed set covers all the standard integer compressed forms. The slots normally used for compressed floating-point loads and stores are given over to six new forms:

- a wide zero-extended immediate load;
- a scaled increment of register a5;
- two short branches with zero-extended offsets whose second register is x0 or a5;
- zero-offset byte and word memory accesses.

Throughout, a 3-bit compact register field c selects register x(8+c). A one-bit "alternate" selector picks x0 when 0 and x15 (a5) when 1.

Top module: `cx_expand`

## Requirements
- R1: If fetchWord[1:0] is 11, expWord equals fetchWord and isIllegal is 0. Every legal compressed input produces an expWord whose two low bits are 11.
- R2: When isIllegal is 1, expWord is all zeros. The following raise isIllegal: the all-zero halfword, quadrant 00 with funct3 100 or 111, quadrant 10 with funct3 111, and the 64-bit-only sub-forms (bit 12 set on the register-register arithmetic group, SRLI, SRAI or SLLI).
- R3: The add-immediate form (quadrant 01, funct3 000) gives addi rd,rd,sext6. It is illegal when the immediate is zero and rd is nonzero; with rd=0 and imm=0 it gives addi x0,x0,0. The load-immediate form (funct3 010) gives addi rd,x0,sext6 and is illegal when rd is x0.
- R4: The following forms are illegal when their immediate is zero:
  - the stack-adjust form (quadrant 01, funct3 011, rd=x2), which adds a sign-extended immediate scaled by 16 (range -512..496) to x2;
  - the upper-immediate form (same slot, rd not x2), which gives lui;
  - the stack-address form (quadrant 00, funct3 000), which gives addi rd',x2,uimm with uimm zero-extended and scaled by 4.
- R5: Quadrant 01 funct3 101 gives jal x0,offset and funct3 001 gives jal x1,offset. The offset is a signed 12-bit value with bit 0 clear.
- R6: Quadrant 01 funct3 110 and 111 give beq and bne respectively, comparing compact rs1 (bits 9:7) against x0. The offset is signed, offset[8:1].
- R7: The standard word load and store forms expand to lw and sw: the compact forms, and the stack-relative forms that use x2 as the base. The stack-relative load is illegal when rd is x0.
- R8: The quadrant 01 funct3 100 group and the quadrant 10 shift-left form expand as follows:
  - SRLI, SRAI and ANDI with compact rd;
  - SUB, XOR, OR and AND, selected by bits 6:5 = 00/01/10/11;
  - SLLI with a full rd.
- R9: The quadrant 10 funct3 100 group expands as follows:
  - bit12=0, rs2=0 gives jalr x0,0(rs1) and is illegal when rs1 is x0;
  - bit12=0, rs2≠0 gives add rd,x0,rs2;
  - bit12=1 with rd=rs2=0 gives ebreak;
  - bit12=1, rs2=0 gives jalr x1,0(rs1);
  - bit12=1, otherwise gives add rd,rd,rs2.
- R10: Quadrant 00 funct3 001 gives addi rd',x0,uimm8, with uimm8 in bits 12:5 (zero-extended) and rd' in bits 4:2. It is never illegal.
- R11: Quadrant 00 funct3 011 gives addi x15,x15,imm. The immediate is bits 12:2 sign-extended and scaled by 2. The form is illegal when those bits are all zero.
- R12: Quadrant 00 funct3 101 is a short branch with this layout:
  - bits 12:9 are offset[4:1] (zero-extended);
  - bit 8 selects bne (1) or beq (0);
  - bits 7:6 must be 00, otherwise the form is illegal;
  - bit 5 is the alternate rs2 selector;
  - bits 4:2 are the compact rs1.
- R13: Quadrant 10 funct3 001 is a short branch with this layout:
  - bits 12:11 select beq, bne, blt or bge (00, 01, 10, 11);
  - bits 10:6 are offset[5:1] (zero-extended);
  - bit 5 is the alternate rs2 selector;
  - bits 4:2 are the compact rs1.
- R14: Quadrant 10 funct3 011 (byte) and 101 (word) are zero-offset memory forms with this layout:
  - bit 12 = 0 gives lbu or lw rd',0(rs1'), and bit 12 = 1 gives sb or sw rs2',0(rs1');
  - rs1' is in bits 9:7 and rd'/rs2' is in bits 4:2;
  - bits 11:10 and 6:5 must be zero, otherwise the form is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetchWord | input | 32 | Fetched word; the low halfword is the compressed candidate |
| expWord | output | 32 | Expanded base instruction, or zero when illegal |
| isIllegal | output | 1 | High when the compressed encoding is not valid |

## Verification
The bench drives several directed corner cases:
- a zero "nonzero" immediate on the increment, stack and add forms, which a careless decoder would accept as a no-op add instead of trapping;
- reserved bits set in the new branch and zero-offset forms, which a design that ignores them would decode as valid branches or accesses;
- the all-ones increment field, where an unsigned extension would add +4094 instead of -2;
- the widest short-branch offset, where a missing zero-extension would turn a forward branch into a backward one.

Random halfwords biased toward the reassigned slots catch swapped compact-register fields and a wrong x0/a5 choice. Those errors show up as an incorrect rs1 or rs2 field in the rebuilt branch or memory instruction.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int ILEN = 32;
  localparam int HLEN = 16;
  localparam int RLEN = 5;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_SYS   = 7'b1110011;

  typedef enum logic [2:0] {
    FMT_ZERO, FMT_PASS, FMT_I, FMT_S, FMT_B, FMT_J, FMT_U, FMT_R
  } FmtKind;

  typedef enum logic [3:0] {
    IM_ZERO, IM_ONE, IM_ADDI6, IM_SPN, IM_SP16, IM_LUI, IM_SHAMT, IM_LW,
    IM_LWSP, IM_SWSP, IM_JOFF, IM_BZ, IM_LI8, IM_INC, IM_BEQ4, IM_BR5
  } ImmKind;

  typedef enum logic [3:0] {
    RS_X0, RS_RA, RS_SP, RS_A5, RS_HI5, RS_LO5, RS_HI3, RS_LO3, RS_ALT
  } RegSrc;

  typedef struct packed {
    FmtKind     fmt;
    ImmKind     imm;
    RegSrc      rd;
    RegSrc      rs1;
    RegSrc      rs2;
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       bad;
  } CtrlStrobe;
endpackage

// File: rtl/cx_ctrl.sv
module cx_ctrl
  import cx_pkg::*;
(
  input  logic [HLEN-1:0] half,
  output CtrlStrobe       ctl
);
  logic [4:0] slot;
  logic       imm6Zero;
  logic [4:0] rdHi;
  logic [4:0] rsLo;

  assign slot     = {half[15:13], half[1:0]};
  assign imm6Zero = ~|{half[12], half[6:2]};
  assign rdHi     = half[11:7];
  assign rsLo     = half[6:2];

  always_comb begin
    ctl     = '0;
    ctl.bad = 1'b1;
    if (half[1:0] == 2'b11) begin
      ctl.fmt = FMT_PASS;
      ctl.bad = 1'b0;
    end else begin
      case (slot)
        5'b000_00: begin ctl.fmt = FMT_I; ctl.imm = IM_SPN; ctl.rd = RS_LO3; ctl.rs1 = RS_SP;
                         ctl.opc = OPC_OPIMM; ctl.bad = ~|half[12:5]; end
        5'b001_00: begin ctl.fmt = FMT_I; ctl.imm = IM_LI8; ctl.rd = RS_LO3; ctl.rs1 = RS_X0;
                         ctl.opc = OPC_OPIMM; ctl.bad = 1'b0; end
        5'b010_00: begin ctl.fmt = FMT_I; ctl.imm = IM_LW; ctl.rd = RS_LO3; ctl.rs1 = RS_HI3;
                         ctl.opc = OPC_LOAD; ctl.f3 = 3'b010; ctl.bad = 1'b0; end
        5'b011_00: begin ctl.fmt = FMT_I; ctl.imm = IM_INC; ctl.rd = RS_A5; ctl.rs1 = RS_A5;
                         ctl.opc = OPC_OPIMM; ctl.bad = ~|half[12:2]; end
        5'b101_00: begin ctl.fmt = FMT_B; ctl.imm = IM_BEQ4; ctl.rs1 = RS_LO3; ctl.rs2 = RS_ALT;
                         ctl.opc = OPC_BR; ctl.f3 = {2'b00, half[8]}; ctl.bad = |half[7:6]; end
        5'b110_00: begin ctl.fmt = FMT_S; ctl.imm = IM_LW; ctl.rs1 = RS_HI3; ctl.rs2 = RS_LO3;
                         ctl.opc = OPC_STORE; ctl.f3 = 3'b010; ctl.bad = 1'b0; end
        5'b000_01: begin ctl.fmt = FMT_I; ctl.imm = IM_ADDI6; ctl.rd = RS_HI5; ctl.rs1 = RS_HI5;
                         ctl.opc = OPC_OPIMM; ctl.bad = imm6Zero & (|rdHi); end
        5'b001_01, 5'b101_01: begin
                         ctl.fmt = FMT_J; ctl.imm = IM_JOFF; ctl.rd = half[15] ? RS_X0 : RS_RA;
                         ctl.opc = OPC_JAL; ctl.bad = 1'b0; end
        5'b010_01: begin ctl.fmt = FMT_I; ctl.imm = IM_ADDI6; ctl.rd = RS_HI5; ctl.rs1 = RS_X0;
                         ctl.opc = OPC_OPIMM; ctl.bad = ~|rdHi; end
        5'b011_01: begin
          if (rdHi == 5'd2) begin
            ctl.fmt = FMT_I; ctl.imm = IM_SP16; ctl.rd = RS_SP; ctl.rs1 = RS_SP;
            ctl.opc = OPC_OPIMM;
          end else begin
            ctl.fmt = FMT_U; ctl.imm = IM_LUI; ctl.rd = RS_HI5; ctl.opc = OPC_LUI;
          end
          ctl.bad = imm6Zero;
        end
        5'b100_01: begin
          ctl.rd = RS_HI3; ctl.rs1 = RS_HI3; ctl.bad = half[12];
          case (half[11:10])
            2'b00: begin ctl.fmt = FMT_I; ctl.imm = IM_SHAMT; ctl.opc = OPC_OPIMM; ctl.f3 = 3'b101; end
            2'b01: begin ctl.fmt = FMT_I; ctl.imm = IM_SHAMT; ctl.opc = OPC_OPIMM; ctl.f3 = 3'b101;
                         ctl.f7 = 7'b0100000; end
            2'b10: begin ctl.fmt = FMT_I; ctl.imm = IM_ADDI6; ctl.opc = OPC_OPIMM; ctl.f3 = 3'b111;
                         ctl.bad = 1'b0; end
            default: begin
              ctl.fmt = FMT_R; ctl.rs2 = RS_LO3; ctl.opc = OPC_OP;
              case (half[6:5])
                2'b00:   begin ctl.f3 = 3'b000; ctl.f7 = 7'b0100000; end
                2'b01:   ctl.f3 = 3'b100;
                2'b10:   ctl.f3 = 3'b110;
                default: ctl.f3 = 3'b111;
              endcase
            end
          endcase
        end
        5'b110_01, 5'b111_01: begin
                         ctl.fmt = FMT_B; ctl.imm = IM_BZ; ctl.rs1 = RS_HI3; ctl.rs2 = RS_X0;
                         ctl.opc = OPC_BR; ctl.f3 = {2'b00, half[13]}; ctl.bad = 1'b0; end
        5'b000_10: begin ctl.fmt = FMT_I; ctl.imm = IM_SHAMT; ctl.rd = RS_HI5; ctl.rs1 = RS_HI5;
                         ctl.opc = OPC_OPIMM; ctl.f3 = 3'b001; ctl.bad = half[12]; end
        5'b001_10: begin ctl.fmt = FMT_B; ctl.imm = IM_BR5; ctl.rs1 = RS_LO3; ctl.rs2 = RS_ALT;
                         ctl.opc = OPC_BR; ctl.f3 = {half[12], 1'b0, half[11]}; ctl.bad = 1'b0; end
        5'b010_10: begin ctl.fmt = FMT_I; ctl.imm = IM_LWSP; ctl.rd = RS_HI5; ctl.rs1 = RS_SP;
                         ctl.opc = OPC_LOAD; ctl.f3 = 3'b010; ctl.bad = ~|rdHi; end
        5'b011_10, 5'b101_10: begin
          ctl.imm = IM_ZERO; ctl.rs1 = RS_HI3;
          ctl.bad = |{half[11:10], half[6:5]};
          if (half[12]) begin
            ctl.fmt = FMT_S; ctl.rs2 = RS_LO3; ctl.opc = OPC_STORE;
            ctl.f3 = half[15] ? 3'b010 : 3'b000;
          end else begin
            ctl.fmt = FMT_I; ctl.rd = RS_LO3; ctl.opc = OPC_LOAD;
            ctl.f3 = half[15] ? 3'b010 : 3'b100;
          end
        end
        5'b100_10: begin
          ctl.bad = 1'b0;
          if (!half[12]) begin
            if (rsLo == 5'd0) begin
              ctl.fmt = FMT_I; ctl.rd = RS_X0; ctl.rs1 = RS_HI5; ctl.opc = OPC_JALR;
              ctl.bad = ~|rdHi;
            end else begin
              ctl.fmt = FMT_R; ctl.rd = RS_HI5; ctl.rs1 = RS_X0; ctl.rs2 = RS_LO5; ctl.opc = OPC_OP;
            end
          end else if (rsLo == 5'd0 && rdHi == 5'd0) begin
            ctl.fmt = FMT_I; ctl.imm = IM_ONE; ctl.opc = OPC_SYS;
          end else if (rsLo == 5'd0) begin
            ctl.fmt = FMT_I; ctl.rd = RS_RA; ctl.rs1 = RS_HI5; ctl.opc = OPC_JALR;
          end else begin
            ctl.fmt = FMT_R; ctl.rd = RS_HI5; ctl.rs1 = RS_HI5; ctl.rs2 = RS_LO5; ctl.opc = OPC_OP;
          end
        end
        5'b110_10: begin ctl.fmt = FMT_S; ctl.imm = IM_SWSP; ctl.rs1 = RS_SP; ctl.rs2 = RS_LO5;
                         ctl.opc = OPC_STORE; ctl.f3 = 3'b010; ctl.bad = 1'b0; end
        default: ctl.bad = 1'b1;
      endcase
      if (ctl.bad) ctl.fmt = FMT_ZERO;
    end
  end
endmodule

// File: rtl/cx_dpath.sv
module cx_dpath
  import cx_pkg::*;
(
  input  logic [ILEN-1:0] fetchWord,
  input  CtrlStrobe       ctl,
  output logic [ILEN-1:0] expWord
);
  logic [HLEN-1:0] c;
  logic [ILEN-1:0] immVal;
  logic [RLEN-1:0] rdNum, rs1Num, rs2Num;

  assign c = fetchWord[HLEN-1:0];

  function automatic logic [RLEN-1:0] pickReg(input RegSrc s, input logic [HLEN-1:0] h);
    case (s)
      RS_RA:   return 5'd1;
      RS_SP:   return 5'd2;
      RS_A5:   return 5'd15;
      RS_HI5:  return h[11:7];
      RS_LO5:  return h[6:2];
      RS_HI3:  return {2'b01, h[9:7]};
      RS_LO3:  return {2'b01, h[4:2]};
      RS_ALT:  return h[5] ? 5'd15 : 5'd0;
      default: return 5'd0;
    endcase
  endfunction

  assign rdNum  = pickReg(ctl.rd, c);
  assign rs1Num = pickReg(ctl.rs1, c);
  assign rs2Num = pickReg(ctl.rs2, c);

  always_comb begin
    case (ctl.imm)
      IM_ONE:   immVal = 32'd1;
      IM_ADDI6: immVal = {{26{c[12]}}, c[12], c[6:2]};
      IM_SPN:   immVal = {22'b0, c[10:7], c[12:11], c[5], c[6], 2'b0};
      IM_SP16:  immVal = {{22{c[12]}}, c[12], c[4:3], c[5], c[2], c[6], 4'b0};
      IM_LUI:   immVal = {{14{c[12]}}, c[12], c[6:2], 12'b0};
      IM_SHAMT: immVal = {20'b0, ctl.f7, c[6:2]};
      IM_LW:    immVal = {25'b0, c[5], c[12:10], c[6], 2'b0};
      IM_LWSP:  immVal = {24'b0, c[3:2], c[12], c[6:4], 2'b0};
      IM_SWSP:  immVal = {24'b0, c[8:7], c[12:9], 2'b0};
      IM_JOFF:  immVal = {{20{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
      IM_BZ:    immVal = {{23{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
      IM_LI8:   immVal = {24'b0, c[12:5]};
      IM_INC:   immVal = {{20{c[12]}}, c[12:2], 1'b0};
      IM_BEQ4:  immVal = {27'b0, c[12:9], 1'b0};
      IM_BR5:   immVal = {26'b0, c[10:6], 1'b0};
      default:  immVal = '0;
    endcase
  end

  always_comb begin
    case (ctl.fmt)
      FMT_PASS: expWord = fetchWord;
      FMT_I:    expWord = {immVal[11:0], rs1Num, ctl.f3, rdNum, ctl.opc};
      FMT_S:    expWord = {immVal[11:5], rs2Num, rs1Num, ctl.f3, immVal[4:0], ctl.opc};
      FMT_B:    expWord = {immVal[12], immVal[10:5], rs2Num, rs1Num, ctl.f3,
                           immVal[4:1], immVal[11], ctl.opc};
      FMT_J:    expWord = {immVal[20], immVal[10:1], immVal[11], immVal[19:12], rdNum, ctl.opc};
      FMT_U:    expWord = {immVal[31:12], rdNum, ctl.opc};
      FMT_R:    expWord = {ctl.f7, rs2Num, rs1Num, ctl.f3, rdNum, ctl.opc};
      default:  expWord = '0;
    endcase
  end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
  import cx_pkg::*;
(
  input  logic [31:0] fetchWord,
  output logic [31:0] expWord,
  output logic        isIllegal
);
  CtrlStrobe ctl;

  cx_ctrl u_ctrl (
    .half (fetchWord[HLEN-1:0]),
    .ctl  (ctl)
  );

  cx_dpath u_dpath (
    .fetchWord (fetchWord),
    .ctl       (ctl),
    .expWord   (expWord)
  );

  assign isIllegal = ctl.bad;
endmodule

// File: rtl/cx_expand_chk.sv
module cx_expand_chk (
  input logic [31:0] fetchWord,
  input logic [31:0] expWord,
  input logic        isIllegal
);
  logic [4:0] slot;
  assign slot = {fetchWord[15:13], fetchWord[1:0]};

  always_comb begin
    if (fetchWord[1:0] == 2'b11)
      AST_PASS_THRU: assert (expWord == fetchWord && !isIllegal) else $error("pass-through broken"); // R1
    if (!isIllegal)
      AST_LEGAL_FULL: assert (expWord[1:0] == 2'b11) else $error("legal output not full length"); // R1
    if (isIllegal)
      AST_ILL_ZERO: assert (expWord == 32'd0) else $error("illegal output not zero"); // R2
    if (fetchWord[15:0] == 16'd0)
      AST_ZERO_HALF: assert (isIllegal) else $error("zero halfword accepted"); // R2
    if (slot == 5'b001_00)
      AST_LI8_LEGAL: assert (!isIllegal && expWord[19:15] == 5'd0) else $error("wide load-immediate wrong"); // R10
    if (slot == 5'b011_00 && !isIllegal)
      AST_INC_A5: assert (expWord[6:0] == 7'b0010011 && expWord[11:7] == 5'd15 && expWord[19:15] == 5'd15)
        else $error("increment not on a5"); // R11
    if (slot == 5'b101_00 && !isIllegal)
      AST_EQBR_RS2: assert (expWord[6:0] == 7'b1100011 && expWord[31] == 1'b0 &&
                            (expWord[24:20] == 5'd0 || expWord[24:20] == 5'd15))
        else $error("short eq branch malformed"); // R12
    if (slot == 5'b001_10 && !isIllegal)
      AST_GENBR_RS2: assert (expWord[6:0] == 7'b1100011 && expWord[31] == 1'b0 &&
                             (expWord[24:20] == 5'd0 || expWord[24:20] == 5'd15))
        else $error("short general branch malformed"); // R13
    if ((slot == 5'b011_10 || slot == 5'b101_10) && !isIllegal) begin
      if (fetchWord[12])
        AST_ZOFF_ST: assert (expWord[31:25] == 7'd0 && expWord[11:7] == 5'd0) else $error("store offset nonzero"); // R14
      else
        AST_ZOFF_LD: assert (expWord[31:20] == 12'd0) else $error("load offset nonzero"); // R14
    end
  end
endmodule

bind cx_expand cx_expand_chk u_chk (
  .fetchWord (fetchWord),
  .expWord   (expWord),
  .isIllegal (isIllegal)
);

// File: tb/sim_cx_expand.sv
`timescale 1ns/1ps
module sim_cx_expand;
  logic        clk = 1'b0;
  logic [31:0] fetchWord = 32'd0;
  logic [31:0] expWord;
  logic        isIllegal;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cx_expand u0 (.fetchWord(fetchWord), .expWord(expWord), .isIllegal(isIllegal));

  localparam logic [6:0] OPI = 7'h13, LDO = 7'h03, STO = 7'h23, OPR = 7'h33, JLR = 7'h67;

  function automatic logic [31:0] sx(input logic [31:0] x, input int msb);
    return x[msb] ? (x | (32'hFFFF_FFFF << msb)) : x;
  endfunction
  function automatic logic [31:0] fI(input logic [31:0] i, input logic [4:0] a, input logic [2:0] f, input logic [4:0] d, input logic [6:0] o);
    return {i[11:0], a, f, d, o};
  endfunction
  function automatic logic [31:0] fS(input logic [31:0] i, input logic [4:0] b, input logic [4:0] a, input logic [2:0] f, input logic [6:0] o);
    return {i[11:5], b, a, f, i[4:0], o};
  endfunction
  function automatic logic [31:0] fB(input logic [31:0] i, input logic [4:0] b, input logic [4:0] a, input logic [2:0] f);
    return {i[12], i[10:5], b, a, f, i[4:1], i[11], 7'h63};
  endfunction
  function automatic logic [31:0] fJ(input logic [31:0] i, input logic [4:0] d);
    return {i[20], i[10:1], i[11], i[19:12], d, 7'h6F};
  endfunction
  function automatic logic [31:0] fR(input logic [6:0] f7, input logic [4:0] b, input logic [4:0] a, input logic [2:0] f, input logic [4:0] d);
    return {f7, b, a, f, d, OPR};
  endfunction

  function automatic void refExpand(input logic [31:0] w, output logic [31:0] e, output logic ill, output string tag);
    logic [15:0] c; logic [4:0] rH, rL, pH, pL, alt; logic [31:0] v; logic [2:0] f;
    c = w[15:0]; rH = c[11:7]; rL = c[6:2];
    pH = 5'd8 + {2'b0, c[9:7]}; pL = 5'd8 + {2'b0, c[4:2]}; alt = c[5] ? 5'd15 : 5'd0;
    e = '0; ill = 1'b0; v = '0; tag = "R2";
    if (w[1:0] == 2'b11) begin e = w; tag = "R1"; return; end
    case ({c[15:13], c[1:0]})
      5'b000_00: begin tag = "R4"; v[5:4] = c[12:11]; v[9:6] = c[10:7]; v[2] = c[6]; v[3] = c[5];
                       ill = (v == 0); e = fI(v, 5'd2, 3'd0, pL, OPI); end
      5'b001_00: begin tag = "R10"; v[7:0] = c[12:5]; e = fI(v, 5'd0, 3'd0, pL, OPI); end
      5'b010_00, 5'b110_00: begin tag = "R7"; v[5:3] = c[12:10]; v[2] = c[6]; v[6] = c[5];
                       e = c[15] ? fS(v, pL, pH, 3'd2, STO) : fI(v, pH, 3'd2, pL, LDO); end
      5'b011_00: begin tag = "R11"; v[11:1] = c[12:2]; v = sx(v, 11); ill = (c[12:2] == 0);
                       e = fI(v, 5'd15, 3'd0, 5'd15, OPI); end
      5'b101_00: begin tag = "R12"; v[4:1] = c[12:9]; ill = (c[7:6] != 0);
                       e = fB(v, alt, pL, {2'b0, c[8]}); end
      5'b000_01: begin tag = "R3"; v[5] = c[12]; v[4:0] = c[6:2]; v = sx(v, 5);
                       ill = (v == 0) && (rH != 0); e = fI(v, rH, 3'd0, rH, OPI); end
      5'b010_01: begin tag = "R3"; v[5] = c[12]; v[4:0] = c[6:2]; v = sx(v, 5);
                       ill = (rH == 0); e = fI(v, 5'd0, 3'd0, rH, OPI); end
      5'b001_01, 5'b101_01: begin tag = "R5";
                       v[11] = c[12]; v[10] = c[8]; v[9:8] = c[10:9]; v[7] = c[6]; v[6] = c[7];
                       v[5] = c[2]; v[4] = c[11]; v[3:1] = c[5:3]; v = sx(v, 11);
                       e = fJ(v, c[15] ? 5'd0 : 5'd1); end
      5'b011_01: begin tag = "R4";
        if (rH == 5'd2) begin
          v[9] = c[12]; v[4] = c[6]; v[6] = c[5]; v[8:7] = c[4:3]; v[5] = c[2]; v = sx(v, 9);
          ill = (v == 0); e = fI(v, 5'd2, 3'd0, 5'd2, OPI);
        end else begin
          v[17] = c[12]; v[16:12] = c[6:2]; v = sx(v, 17); ill = (v == 0);
          e = {v[31:12], rH, 7'h37};
        end
      end
      5'b100_01: begin tag = "R8";
        case (c[11:10])
          2'd0: begin ill = c[12]; v[4:0] = c[6:2]; e = fI(v, pH, 3'd5, pH, OPI); end
          2'd1: begin ill = c[12]; v[4:0] = c[6:2]; v[10] = 1'b1; e = fI(v, pH, 3'd5, pH, OPI); end
          2'd2: begin v[5] = c[12]; v[4:0] = c[6:2]; v = sx(v, 5); e = fI(v, pH, 3'd7, pH, OPI); end
          default: begin
            ill = c[12];
            f = (c[6:5] == 0) ? 3'd0 : (c[6:5] == 1) ? 3'd4 : (c[6:5] == 2) ? 3'd6 : 3'd7;
            e = fR((c[6:5] == 0) ? 7'h20 : 7'h00, pL, pH, f, pH);
          end
        endcase
      end
      5'b110_01, 5'b111_01: begin tag = "R6";
        v[8] = c[12]; v[4:3] = c[11:10]; v[7:6] = c[6:5]; v[2:1] = c[4:3]; v[5] = c[2]; v = sx(v, 8);
        e = fB(v, 5'd0, pH, {2'b0, c[13]}); end
      5'b000_10: begin tag = "R8"; ill = c[12]; v[4:0] = c[6:2]; e = fI(v, rH, 3'd1, rH, OPI); end
      5'b001_10: begin tag = "R13"; v[5:1] = c[10:6]; e = fB(v, alt, pL, {c[12], 1'b0, c[11]}); end
      5'b010_10: begin tag = "R7"; v[5] = c[12]; v[4:2] = c[6:4]; v[7:6] = c[3:2];
                       ill = (rH == 0); e = fI(v, 5'd2, 3'd2, rH, LDO); end
      5'b011_10, 5'b101_10: begin tag = "R14";
        ill = (c[11:10] != 0) || (c[6:5] != 0);
        e = c[12] ? fS(32'd0, pL, pH, c[15] ? 3'd2 : 3'd0, STO)
                  : fI(32'd0, pH, c[15] ? 3'd2 : 3'd4, pL, LDO);
      end
      5'b100_10: begin tag = "R9";
        if (!c[12]) begin
          if (rL == 0) begin ill = (rH == 0); e = fI(32'd0, rH, 3'd0, 5'd0, JLR); end
          else e = fR(7'd0, rL, 5'd0, 3'd0, rH);
        end else if (rH == 0 && rL == 0) e = 32'h0010_0073;
        else if (rL == 0) e = fI(32'd0, rH, 3'd0, 5'd1, JLR);
        else e = fR(7'd0, rL, rH, 3'd0, rH);
      end
      5'b110_10: begin tag = "R7"; v[5:2] = c[12:9]; v[7:6] = c[8:7]; e = fS(v, rL, 5'd2, 3'd2, STO); end
      default: begin tag = "R2"; ill = 1'b1; end
    endcase
    if (ill) e = '0;
  endfunction

  task automatic compare(input logic [31:0] w, input logic [31:0] e, input logic i, input string tag);
    nChk++;
    if (expWord !== e || isIllegal !== i) begin
      nBad++;
      $display("FAIL %s in=%08h actual=%08h/%0b expected=%08h/%0b", tag, w, expWord, isIllegal, e, i);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk); fetchWord = w;
    @(posedge clk); #1;
  endtask

  task automatic runRef(input logic [31:0] w);
    logic [31:0] e; logic i; string t;
    refExpand(w, e, i, t);
    apply(w);
    compare(w, e, i, t);
  endtask

  task automatic runLit(input logic [31:0] w, input logic [31:0] e, input logic i, input string tag);
    apply(w);
    compare(w, e, i, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    // reset state: zero input must be illegal with zero output (R2)
    @(posedge clk); #1;
    compare(32'd0, 32'd0, 1'b1, "R2");
    runLit(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, "R1");
    runLit(32'h1234_5677, 32'h1234_5677, 1'b0, "R1");
    runLit(32'h0000_8000, 32'd0, 1'b1, "R2");
    runLit(32'h0000_E002, 32'd0, 1'b1, "R2");
    runLit(32'h0000_9001, 32'd0, 1'b1, "R8");
    runLit(32'h0000_0001, 32'h0000_0013, 1'b0, "R3");
    runLit(32'h0000_4005, 32'd0, 1'b1, "R3");
    runLit(32'h0000_0004, 32'd0, 1'b1, "R4");
    runLit(32'h0000_8002, 32'd0, 1'b1, "R9");
    runLit(32'h0000_9002, 32'h0010_0073, 1'b0, "R9");
    runLit(32'h0000_3FE0, 32'h0FF0_0413, 1'b0, "R10");
    runLit(32'h0000_7FFC, 32'hFFE7_8793, 1'b0, "R11");
    runLit(32'h0000_6000, 32'd0, 1'b1, "R11");
    runLit(32'h0000_A040, 32'd0, 1'b1, "R12");
    runLit(32'h0000_3FE2, 32'h02F4_5F63, 1'b0, "R13");
    runLit(32'h0000_6402, 32'd0, 1'b1, "R14");
    runRef(32'h0000_1101); runRef(32'h0000_6141); runRef(32'h0000_7139);
    runRef(32'h0000_A001); runRef(32'h0000_2001); runRef(32'h0000_C001);
    runRef(32'h0000_4398); runRef(32'h0000_C398); runRef(32'h0000_4082);
    runRef(32'h0000_C206); runRef(32'h0000_8C1D); runRef(32'h0000_0506);
    runRef(32'h0000_B100); runRef(32'h0000_B3A0); runRef(32'h0000_7102); runRef(32'h0000_B102);
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      if (n % 2 == 0) begin
        r[1:0] = (n % 4 == 0) ? 2'b00 : 2'b10;
        r[15:13] = {$urandom_range(0, 3) == 0 ? 1'b0 : r[15], r[14], 1'b1};
      end
      runRef(r);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule